// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block keeps one poison token bit for every architectural register of a core that speculates on control flow. A load that is issued ahead of the branch guarding it does not trap when it faults. The fault is recorded as a token on that load's destination register. Any operation that reads a poisoned register passes the poison on to its own result. Nothing happens until a speculation check reads such a register. The check then sends fetch to the recovery address that came with it.

Each cycle the block can accept four events, one of each kind:
- a completing speculative load, with a fault flag;
- an ALU operation with two source registers and one destination;
- a non-speculative write, which covers a plain load or a move whose source is known to be clean;
- a speculation check.

The block outputs the full token vector and a registered redirect pulse that carries the recovery address. It holds no register values. It neither performs memory access nor delivers exceptions.

Top module: `dtt_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every token is cleared and `redir_vld` is 0 after that edge.
- R2: A speculative load to register d (d not 0) sets token d to the value of `sld_fault` after the edge.
- R3: An ALU operation writing register d (d not 0) sets token d to the OR of the tokens of `alu_src_a` and `alu_src_b`. Both source tokens are taken as they stood before the edge.
- R4: A non-speculative write to register d clears token d after the edge.
- R5: Register 0 always has its token clear (`tok_vec[0]` = 0). Any write of any kind to register 0 has no effect.
- R6: A check on a register whose token is set drives `redir_vld` = 1 and `redir_addr` = `chk_target` in the cycle after the check.
- R7: A check on a register whose token is clear raises no redirect.
- R8: A check reads the token as it stood before any write to the same register in the same cycle.
- R9: `redir_vld` is a single-cycle pulse for each failing check. It is 0 in any cycle that does not follow a failing check.
- R10: When several writes target the same register in one cycle, they take effect in this order of priority: the non-speculative write first, then the ALU operation, then the speculative load.
- R11: A check alone does not change any token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sld_vld | input | 1 | Speculative load completes this cycle |
| sld_dst | input | RW | Destination register of the speculative load |
| sld_fault | input | 1 | The speculative load hit a fault |
| alu_vld | input | 1 | ALU operation writes back this cycle |
| alu_src_a | input | RW | First source register |
| alu_src_b | input | RW | Second source register (use 0 for a single-source operation) |
| alu_dst | input | RW | ALU destination register |
| nsw_vld | input | 1 | Non-speculative write this cycle |
| nsw_dst | input | RW | Destination of the non-speculative write |
| chk_vld | input | 1 | Speculation check this cycle |
| chk_reg | input | RW | Register tested by the check |
| chk_target | input | AW | Recovery address of the check |
| tok_vec | output | NREG | Token bit for each register |
| redir_vld | output | 1 | Redirect pulse, one cycle after a failing check |
| redir_addr | output | AW | Recovery address for the redirect |

## Verification
The properties assume that every event input is a known value at each sampled edge. They also assume that register indices lie within the register count, which always holds when NREG is a power of two. The ALU and load properties exclude cycles in which a higher-priority write hits the same destination. The priority rule itself is left to the reference model. The bench drives each input from a task on the falling edge and never leaves an input undriven. It draws register indices from a narrow low range so that same-register collisions, including collisions on register 0, occur often and still stay within the assumptions.

// File: rtl/dtt_pkg.sv
// Package: dtt_pkg
// Shared types for the deferred exception token tracker.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dtt_pkg;

    // Which event wins the write to one token bit this cycle.
    typedef enum logic [1:0] {
        WSRC_KEEP = 2'd0,
        WSRC_SLD  = 2'd1,
        WSRC_ALU  = 2'd2,
        WSRC_NSW  = 2'd3
    } wsrc_e;

endpackage

// File: rtl/dtt_src_read.sv
// Module: dtt_src_read
// Reads one token bit out of the token vector by register index.
// Register 0 always reads as clear. Assumes NREG == 2**RW.
module dtt_src_read #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic [NREG-1:0] tok_i,
    input  logic [RW-1:0]   idx_i,
    output logic            bit_o
);

    // Index the token vector, forcing register 0 to clear.
    always_comb begin
        if (idx_i == '0) bit_o = 1'b0;
        else             bit_o = tok_i[idx_i];
    end

endmodule

// File: rtl/dtt_token_bank.sv
// Module: dtt_token_bank
// Holds one token flop per register (register 0 has no flop).
// Each register picks its write source by fixed priority:
// non-speculative write > ALU > speculative load.
// Assumes the ALU result token has already been formed from pre-edge state.
module dtt_token_bank
    import dtt_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sld_vld,
    input  logic [RW-1:0]   sld_dst,
    input  logic            sld_fault,
    input  logic            alu_vld,
    input  logic [RW-1:0]   alu_dst,
    input  logic            alu_tok,
    input  logic            nsw_vld,
    input  logic [RW-1:0]   nsw_dst,
    output logic [NREG-1:0] tok_o
);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        if (gi == 0) begin : g_zero
            assign tok_o[gi] = 1'b0;
        end else begin : g_live
            localparam logic [RW-1:0] IDX = RW'(gi);
            wsrc_e sel;
            logic  tok_q;

            // Choose which event writes this register this cycle.
            always_comb begin
                if (nsw_vld && nsw_dst == IDX)      sel = WSRC_NSW;
                else if (alu_vld && alu_dst == IDX) sel = WSRC_ALU;
                else if (sld_vld && sld_dst == IDX) sel = WSRC_SLD;
                else                                sel = WSRC_KEEP;
            end

            // Token flop with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok_q <= 1'b0;
                end else begin
                    unique case (sel)
                        WSRC_NSW:  tok_q <= 1'b0;
                        WSRC_ALU:  tok_q <= alu_tok;
                        WSRC_SLD:  tok_q <= sld_fault;
                        default:   tok_q <= tok_q;
                    endcase
                end
            end

            assign tok_o[gi] = tok_q;
        end
    end

endmodule

// File: rtl/dtt_redirect.sv
// Module: dtt_redirect
// Registers the redirect for a failing check: a one-cycle pulse with
// the recovery address. Assumes fail_i is already qualified by chk valid.
module dtt_redirect #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_i,
    input  logic [AW-1:0] target_i,
    output logic          redir_vld,
    output logic [AW-1:0] redir_addr
);

    // Capture the pulse and its address one cycle after the check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_vld  <= 1'b0;
            redir_addr <= '0;
        end else begin
            redir_vld <= fail_i;
            if (fail_i) redir_addr <= target_i;
        end
    end

endmodule

// File: rtl/dtt_tracker.sv
// Module: dtt_tracker (top)
// Deferred exception token tracker: per-register poison bits that
// speculative loads set on a fault and that ALU operations propagate.
// A speculation check that reads a set token redirects to recovery.
// All reads (ALU sources, check) see token state from before the edge.
// Assumes NREG is a power of two and at most one event of each kind per cycle.
module dtt_tracker #(
    parameter int NREG = 32,
    parameter int AW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sld_vld,
    input  logic [RW-1:0]   sld_dst,
    input  logic            sld_fault,
    input  logic            alu_vld,
    input  logic [RW-1:0]   alu_src_a,
    input  logic [RW-1:0]   alu_src_b,
    input  logic [RW-1:0]   alu_dst,
    input  logic            nsw_vld,
    input  logic [RW-1:0]   nsw_dst,
    input  logic            chk_vld,
    input  logic [RW-1:0]   chk_reg,
    input  logic [AW-1:0]   chk_target,
    output logic [NREG-1:0] tok_vec,
    output logic            redir_vld,
    output logic [AW-1:0]   redir_addr
);

    logic tok_a, tok_b, tok_chk, alu_tok, chk_fail;

    u_rd_a_inst: begin end
    dtt_src_read #(.NREG(NREG)) u_rd_a (.tok_i(tok_vec), .idx_i(alu_src_a), .bit_o(tok_a));
    dtt_src_read #(.NREG(NREG)) u_rd_b (.tok_i(tok_vec), .idx_i(alu_src_b), .bit_o(tok_b));
    dtt_src_read #(.NREG(NREG)) u_rd_c (.tok_i(tok_vec), .idx_i(chk_reg),   .bit_o(tok_chk));

    // Result token of the ALU operation and the check outcome.
    always_comb begin
        alu_tok  = tok_a | tok_b;
        chk_fail = chk_vld & tok_chk;
    end

    dtt_token_bank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sld_vld   (sld_vld),
        .sld_dst   (sld_dst),
        .sld_fault (sld_fault),
        .alu_vld   (alu_vld),
        .alu_dst   (alu_dst),
        .alu_tok   (alu_tok),
        .nsw_vld   (nsw_vld),
        .nsw_dst   (nsw_dst),
        .tok_o     (tok_vec)
    );

    dtt_redirect #(.AW(AW)) u_redir (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_i     (chk_fail),
        .target_i   (chk_target),
        .redir_vld  (redir_vld),
        .redir_addr (redir_addr)
    );

endmodule

// File: rtl/dtt_tracker_chk.sv
// Module: dtt_tracker_chk
// Assertion checker for dtt_tracker, bound to every instance.
// Assumes known inputs and in-range register indices.
module dtt_tracker_chk #(
    parameter int NREG = 32,
    parameter int AW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sld_vld,
    input logic [RW-1:0]   sld_dst,
    input logic            sld_fault,
    input logic            alu_vld,
    input logic [RW-1:0]   alu_src_a,
    input logic [RW-1:0]   alu_src_b,
    input logic [RW-1:0]   alu_dst,
    input logic            nsw_vld,
    input logic [RW-1:0]   nsw_dst,
    input logic            chk_vld,
    input logic [RW-1:0]   chk_reg,
    input logic [AW-1:0]   chk_target,
    input logic [NREG-1:0] tok_vec,
    input logic            redir_vld,
    input logic [AW-1:0]   redir_addr
);

    // R1: reset clears redirect and tokens
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!redir_vld && tok_vec == '0));

    // R2: unopposed speculative load writes its fault flag
    p_sld_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sld_vld && sld_dst != '0 && !(nsw_vld && nsw_dst == sld_dst)
         && !(alu_vld && alu_dst == sld_dst))
        |=> tok_vec[$past(sld_dst)] == $past(sld_fault));

    // R3: ALU result token is OR of pre-edge source tokens
    p_alu_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld && alu_dst != '0 && !(nsw_vld && nsw_dst == alu_dst))
        |=> tok_vec[$past(alu_dst)] ==
            ($past(tok_vec[alu_src_a]) | $past(tok_vec[alu_src_b])));

    // R4: non-speculative write clears
    p_nsw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nsw_vld |=> !tok_vec[$past(nsw_dst)]);

    // R5: register 0 never poisoned
    p_zero_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_vec[0]);

    // R6: failing check redirects with its target
    p_redir_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && tok_vec[chk_reg]) |=> (redir_vld && redir_addr == $past(chk_target)));

    // R7: passing check stays quiet
    p_chk_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && !tok_vec[chk_reg]) |=> !redir_vld);

    // R9: no redirect without a check in the prior cycle
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |=> !redir_vld);

    // R11: a cycle with no write leaves tokens unchanged
    p_chk_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sld_vld && !alu_vld && !nsw_vld) |=> $stable(tok_vec));

endmodule

bind dtt_tracker dtt_tracker_chk #(.NREG(NREG), .AW(AW)) u_chk (.*);

// File: tb/dtt_tracker_bench.sv
`timescale 1ns/1ps
module dtt_tracker_bench;
    localparam int NREG = 32;
    localparam int AW   = 32;
    localparam int RW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sld_vld, sld_fault, alu_vld, nsw_vld, chk_vld;
    logic [RW-1:0]   sld_dst, alu_src_a, alu_src_b, alu_dst, nsw_dst, chk_reg;
    logic [AW-1:0]   chk_target;
    logic [NREG-1:0] tok_vec;
    logic            redir_vld;
    logic [AW-1:0]   redir_addr;

    dtt_tracker #(.NREG(NREG), .AW(AW)) u_dtt_tracker (.*);

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Behavioural reference: token per register, redirect expectation queue
    int ref_tok [NREG];
    int exp_rv;
    longint exp_ra;
    longint last_ra = 0;

    task automatic idle_inputs();
        sld_vld = 0; sld_fault = 0; sld_dst = '0;
        alu_vld = 0; alu_src_a = '0; alu_src_b = '0; alu_dst = '0;
        nsw_vld = 0; nsw_dst = '0;
        chk_vld = 0; chk_reg = '0; chk_target = '0;
    endtask

    // Advance model and design by one clock; compare at the falling edge.
    task automatic cycle(string tag);
        int nxt [NREG];
        int ta, tb;
        if (!rst_n) begin
            foreach (nxt[i]) nxt[i] = 0;
            exp_rv = 0; exp_ra = 0; last_ra = 0;
        end else begin
            foreach (nxt[i]) nxt[i] = ref_tok[i];
            ta = (alu_src_a == 0) ? 0 : ref_tok[alu_src_a];
            tb = (alu_src_b == 0) ? 0 : ref_tok[alu_src_b];
            exp_rv = (chk_vld && chk_reg != 0 && ref_tok[chk_reg] != 0) ? 1 : 0;
            if (exp_rv) last_ra = chk_target;
            exp_ra = last_ra;
            if (sld_vld && sld_dst != 0) nxt[sld_dst] = sld_fault;
            if (alu_vld && alu_dst != 0) nxt[alu_dst] = ta | tb;
            if (nsw_vld && nsw_dst != 0) nxt[nsw_dst] = 0;
        end
        foreach (nxt[i]) ref_tok[i] = nxt[i];
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NREG; i++) begin
            checks++;
            if (int'(tok_vec[i]) != ref_tok[i]) begin
                failures++;
                $display("FAIL %s tok[%0d] actual=%0d expected=%0d", tag, i, tok_vec[i], ref_tok[i]);
            end
        end
        checks++;
        if (int'(redir_vld) != exp_rv) begin
            failures++;
            $display("FAIL %s redir_vld actual=%0d expected=%0d", tag, redir_vld, exp_rv);
        end
        if (exp_rv) begin
            checks++;
            if (longint'(redir_addr) != exp_ra) begin
                failures++;
                $display("FAIL %s redir_addr actual=%0h expected=%0h", tag, redir_addr, exp_ra);
            end
        end
        idle_inputs();
    endtask

    task automatic do_sld(int d, int f);
        sld_vld = 1; sld_dst = RW'(d); sld_fault = f[0];
    endtask
    task automatic do_alu(int d, int a, int b);
        alu_vld = 1; alu_dst = RW'(d); alu_src_a = RW'(a); alu_src_b = RW'(b);
    endtask
    task automatic do_nsw(int d);
        nsw_vld = 1; nsw_dst = RW'(d);
    endtask
    task automatic do_chk(int r, int t);
        chk_vld = 1; chk_reg = RW'(r); chk_target = AW'(t);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        foreach (ref_tok[i]) ref_tok[i] = 0;
        exp_rv = 0; exp_ra = 0;
        rst_n = 0;
        @(negedge clk);
        // Dirty the state during reset; reset must win.
        do_sld(3, 1);
        cycle("R1 reset");
        cycle("R1 reset");
        rst_n = 1;

        do_sld(5, 1);      cycle("R2 fault sets");
        do_sld(5, 0);      cycle("R2 clean clears");
        do_sld(5, 1);      cycle("R2 fault sets again");
        do_alu(7, 5, 0);   cycle("R3 propagate");
        do_alu(8, 1, 2);   cycle("R3 clean sources");
        do_alu(6, 8, 7);   cycle("R3 OR second source");
        do_chk(7, 'h1234); cycle("R6 failing check");
        cycle("R9 pulse ends");
        do_chk(8, 'h5678); cycle("R7 passing check");
        do_nsw(7);         cycle("R4 nsw clears");
        do_sld(0, 1);      cycle("R5 write to r0 ignored");
        do_alu(0, 5, 6);   cycle("R5 alu to r0 ignored");
        do_chk(0, 'h99);   cycle("R5 check on r0 quiet");
        do_sld(9, 1); do_chk(9, 'h40);  cycle("R8 check sees old clear");
        do_nsw(9); do_chk(9, 'h44);     cycle("R8 check sees old set");
        do_sld(10, 1); do_nsw(10);      cycle("R10 nsw beats sld");
        do_sld(11, 1);                  cycle("R10 setup");
        do_alu(10, 11, 0); do_sld(10, 0); cycle("R10 alu beats sld");
        do_alu(10, 0, 0); do_sld(10, 1);  cycle("R10 alu clean beats faulting sld");
        do_alu(12, 11, 0); do_nsw(12);    cycle("R10 nsw beats alu");
        do_chk(11, 'hA0); cycle("R11 check leaves tokens");
        do_chk(11, 'hA4); cycle("R11 back-to-back pulse");
        do_chk(5, 'hA8);  cycle("R6 target follows check");
        cycle("R9 idle");

        // Random phase with a narrow register range for collisions.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 1)) do_sld($urandom_range(0, 7), $urandom_range(0, 1));
            if ($urandom_range(0, 1)) do_alu($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) do_nsw($urandom_range(0, 7));
            if ($urandom_range(0, 1)) do_chk($urandom_range(0, 7), int'($urandom));
            cycle("R3/R6/R8/R10 random");
        end

        // Reset again mid-run.
        do_sld(4, 1);
        cycle("R2 before reset");
        rst_n = 0;
        do_chk(4, 'h77);
        cycle("R1 mid-run reset");
        rst_n = 1;
        cycle("R1 after reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule